// File: doc/BRIEF.md
# UART FIFO Status and Interrupt Unit

This unit sits between a UART frame transceiver and the host-side register decoder. It buffers received characters, together with their per-character parity and framing error marks, in a receive FIFO. It buffers host characters waiting for the serializer in a transmit FIFO. From the fill levels and a few event sources it builds an 11-bit status word. A 9-bit interrupt enable register masks status bits 0 to 8 onto a single interrupt line.

Receive-side conditions are held in the unit itself:
- **Overrun.** A character that arrives while the receive FIFO is full is discarded and latched as an overrun. The overrun clears on the next read of a stored character.
- **Idle timeout.** The timeout flag rises when the receive FIFO holds data and neither a new character nor a host read has occurred for a programmed number of character times.
- **Character time.** One character time is 16 ticks of the 16x oversampling strobe for each bit of a frame.

Separate strobes empty each FIFO.

Top module: `uart_fifo_status`

## Requirements
- R1: After reset both FIFOs are empty, the overrun and timeout flags are clear and the enable register is zero. With the serializer idle and no NACK, `status` reads 11'h006 and `irq` is 0.
- R2: Received characters are presented on `rx_word` in arrival order. Bit 0 of `status` is 1 while the receive FIFO holds at least one entry. `rx_word` bits 7:0 carry the data, bit 8 the parity error mark and bit 9 the framing error mark.
- R3: Level flags, where `DEPTH` is the FIFO size:
  - Status bit 8 is 1 when the receive count is at least DEPTH/2.
  - Bit 2 is 1 when the transmit count is at most DEPTH/2.
  - Bit 6 is 1 when the transmit FIFO is not empty.
  - Bit 9 is 1 when the transmit FIFO holds DEPTH entries.
- R4: Transmit characters leave on `tx_char_out` in push order, one for each `tx_take`. A push into a full transmit FIFO, without a take in the same cycle, is dropped.
- R5: A character that arrives while the receive FIFO is full, with no pop in the same cycle, is discarded and sets status bit 5. The stored contents are unchanged.
- R6: Status bit 5 clears when the host pops a stored character or pulses `rx_flush`.
- R7: Status bits 3 and 4 show the parity error mark and the framing error mark of the character at the head of the receive FIFO. Both bits are 0 when the FIFO is empty.
- R8: Status bit 1 is 1 only when the transmit FIFO is empty and `tx_busy` is low.
- R9: A `rx_flush` or `tx_flush` pulse empties the matching FIFO. A push in the same cycle is dropped.
- R10: The timeout flag (status bit 7):
  - It sets after `tmo_chars` character times with no received character and no pop while the receive FIFO is not empty. One character time is 16·CHAR_BITS ticks of `tick16`.
  - Any received character or pop restarts the count and clears the flag.
  - An empty FIFO also clears the flag.
  - A `tmo_chars` value of 0 never sets the flag.
- R11: `ien_we` loads `ien_wdata` into the enable register. `irq` is the OR of status bits 0 to 8, each ANDed with the enable bit at the same position.
- R12: Status bit 10 follows the `nack` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Transceiver delivers a received character |
| rx_char | input | 8 | Received character data |
| rx_perr | input | 1 | Parity error mark of the received character |
| rx_ferr | input | 1 | Framing error mark of the received character |
| rx_pop | input | 1 | Host reads (removes) the head receive entry |
| rx_word | output | 10 | Head receive entry: {ferr, perr, data} |
| tx_push | input | 1 | Host writes a transmit character |
| tx_char | input | 8 | Transmit character from the host |
| tx_take | input | 1 | Serializer removes the head transmit character |
| tx_char_out | output | 8 | Head transmit character |
| tx_busy | input | 1 | Serializer shift register is active |
| nack | input | 1 | NACK indication from the transceiver |
| tx_flush | input | 1 | Empties the transmit FIFO |
| rx_flush | input | 1 | Empties the receive FIFO |
| tmo_chars | input | 8 | Idle timeout in character times |
| tick16 | input | 1 | 16x oversampling strobe |
| ien_we | input | 1 | Write strobe for the enable register |
| ien_wdata | input | 9 | New enable register value |
| status | output | 11 | Status word |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the unit with DEPTH=8 and CHAR_BITS=2. The shallow FIFOs let the bench reach the full, half and overrun boundaries in a handful of pushes. The short 32-tick character time lets it probe the exact tick on which the idle timeout fires, and the restart after activity, without long runs. A scoreboard of expected receive and transmit entries, with a model of the overrun and timeout flags, predicts the whole status word and interrupt line after every operation.

// File: rtl/ufs_pkg.sv
package ufs_pkg;

    localparam int CHAR_W = 8;
    localparam int STAT_W = 11;
    localparam int IEN_W  = 9;

    // status bit positions (shared with the enable register for 0..8)
    localparam int ST_RXNE   = 0;
    localparam int ST_TXIDLE = 1;
    localparam int ST_TXHE   = 2;
    localparam int ST_PERR   = 3;
    localparam int ST_FERR   = 4;
    localparam int ST_OVR    = 5;
    localparam int ST_TXNE   = 6;
    localparam int ST_TMO    = 7;
    localparam int ST_RXHF   = 8;
    localparam int ST_TXFULL = 9;
    localparam int ST_NACK   = 10;

    typedef struct packed {
        logic              ferr;
        logic              perr;
        logic [CHAR_W-1:0] data;
    } rx_word_t;

    localparam int RXW_W = $bits(rx_word_t);

    function automatic logic masked_any(input logic [STAT_W-1:0] st,
                                        input logic [IEN_W-1:0]  en);
        return |(st[IEN_W-1:0] & en);
    endfunction

endpackage

// File: rtl/ufs_fifo.sv
module ufs_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       empty,
    output logic                       full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          do_pop, do_push;

    assign empty  = (cnt == '0);
    assign full   = (cnt == FULL_CNT);
    assign do_pop = pop && !empty && !flush;
    assign do_push = push && (!full || do_pop) && !flush;
    assign rdata  = mem[rd_ptr];
    assign count  = cnt;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/ufs_idle_timer.sv
module ufs_idle_timer #(
    parameter int CHAR_BITS = 10,
    parameter int TMO_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             activity,
    input  logic             fifo_empty,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    localparam int TICKS_PER_CHAR = 16 * CHAR_BITS;
    localparam int SW = $clog2(TICKS_PER_CHAR);
    localparam logic [SW-1:0] SUB_LAST = SW'(TICKS_PER_CHAR - 1);

    logic [SW-1:0]    sub_cnt;
    logic [TMO_W-1:0] char_cnt;
    logic [TMO_W:0]   next_chars;

    assign next_chars = {1'b0, char_cnt} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || activity || fifo_empty) begin
            sub_cnt  <= '0;
            char_cnt <= '0;
            expired  <= 1'b0;
        end else if (tick) begin
            if (sub_cnt == SUB_LAST) begin
                sub_cnt <= '0;
                if (char_cnt != '1) char_cnt <= char_cnt + 1'b1;
                if (limit != '0 && next_chars >= {1'b0, limit})
                    expired <= 1'b1;
            end else begin
                sub_cnt <= sub_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ufs_status.sv
module ufs_status
    import ufs_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [$clog2(DEPTH):0] rx_cnt,
    input  logic [$clog2(DEPTH):0] tx_cnt,
    input  rx_word_t               rx_head,
    input  logic                   ovr,
    input  logic                   tmo,
    input  logic                   tx_busy,
    input  logic                   nack,
    input  logic                   ien_we,
    input  logic [IEN_W-1:0]       ien_wdata,
    output logic [STAT_W-1:0]      status,
    output logic                   irq
);
    localparam int CW = $clog2(DEPTH) + 1;
    localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [IEN_W-1:0] ien;
    logic             rx_ne;

    always_ff @(posedge clk) begin
        if (rst)         ien <= '0;
        else if (ien_we) ien <= ien_wdata;
    end

    assign rx_ne = (rx_cnt != '0);

    always_comb begin
        status            = '0;
        status[ST_RXNE]   = rx_ne;
        status[ST_TXIDLE] = (tx_cnt == '0) && !tx_busy;
        status[ST_TXHE]   = (tx_cnt <= HALF);
        status[ST_PERR]   = rx_ne && rx_head.perr;
        status[ST_FERR]   = rx_ne && rx_head.ferr;
        status[ST_OVR]    = ovr;
        status[ST_TXNE]   = (tx_cnt != '0);
        status[ST_TMO]    = tmo;
        status[ST_RXHF]   = (rx_cnt >= HALF);
        status[ST_TXFULL] = (tx_cnt == FULL);
        status[ST_NACK]   = nack;
    end

    assign irq = masked_any(status, ien);
endmodule

// File: rtl/uart_fifo_status.sv
module uart_fifo_status
    import ufs_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int CHAR_BITS = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_char,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_pop,
    output logic [9:0]        rx_word,
    input  logic              tx_push,
    input  logic [7:0]        tx_char,
    input  logic              tx_take,
    output logic [7:0]        tx_char_out,
    input  logic              tx_busy,
    input  logic              nack,
    input  logic              tx_flush,
    input  logic              rx_flush,
    input  logic [7:0]        tmo_chars,
    input  logic              tick16,
    input  logic              ien_we,
    input  logic [8:0]        ien_wdata,
    output logic [10:0]       status,
    output logic              irq
);
    localparam int CW = $clog2(DEPTH) + 1;

    rx_word_t      rx_in, rx_head;
    logic [CW-1:0] rx_cnt, tx_cnt;
    logic          rx_empty, rx_full, tx_empty, tx_full;
    logic          ovr, tmo, activity;

    assign rx_in = '{ferr: rx_ferr, perr: rx_perr, data: rx_char};

    ufs_fifo #(.W(RXW_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst(rst), .flush(rx_flush),
        .push(rx_valid), .wdata(rx_in), .pop(rx_pop),
        .rdata(rx_head), .count(rx_cnt), .empty(rx_empty), .full(rx_full)
    );

    ufs_fifo #(.W(CHAR_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst(rst), .flush(tx_flush),
        .push(tx_push), .wdata(tx_char), .pop(tx_take),
        .rdata(tx_char_out), .count(tx_cnt), .empty(tx_empty), .full(tx_full)
    );

    // overrun: arrival into a full FIFO with no simultaneous pop
    always_ff @(posedge clk) begin
        if (rst || rx_flush)                    ovr <= 1'b0;
        else if (rx_valid && rx_full && !rx_pop) ovr <= 1'b1;
        else if (rx_pop && !rx_empty)            ovr <= 1'b0;
    end

    assign activity = rx_valid || (rx_pop && !rx_empty) || rx_flush;

    ufs_idle_timer #(.CHAR_BITS(CHAR_BITS), .TMO_W(8)) u_timer (
        .clk(clk), .rst(rst), .tick(tick16), .activity(activity),
        .fifo_empty(rx_empty), .limit(tmo_chars), .expired(tmo)
    );

    ufs_status #(.DEPTH(DEPTH)) u_status (
        .clk(clk), .rst(rst), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
        .rx_head(rx_head), .ovr(ovr), .tmo(tmo), .tx_busy(tx_busy),
        .nack(nack), .ien_we(ien_we), .ien_wdata(ien_wdata),
        .status(status), .irq(irq)
    );

    assign rx_word = rx_head;
endmodule

// File: rtl/ufs_checker.sv
module ufs_checker (
    input logic        clk,
    input logic        rst,
    input logic        rx_valid,
    input logic        rx_pop,
    input logic        rx_full,
    input logic        rx_flush,
    input logic        tx_flush,
    input logic        tx_push,
    input logic        tx_take,
    input logic [10:0] status,
    input logic        irq
);
    // R5
    ovr_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_full && !rx_pop && !rx_flush) |=> status[5]);
    // R6
    ovr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ((rx_pop && status[0]) || rx_flush) |=> !status[5]);
    // R3
    tx_full_level_chk: assert property (@(posedge clk) disable iff (rst)
        status[9] |-> (status[6] && !status[2]));
    // R4
    tx_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (status[9] && tx_push && !tx_take && !tx_flush) |=> status[9]);
    // R8
    tx_idle_chk: assert property (@(posedge clk) disable iff (rst)
        status[1] |-> !status[6]);
    // R9
    rx_flush_chk: assert property (@(posedge clk) disable iff (rst)
        rx_flush |=> !status[0]);
    // R9
    tx_flush_chk: assert property (@(posedge clk) disable iff (rst)
        tx_flush |=> !status[6]);
    // R10
    tmo_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
        status[7] |-> status[0]);
    // R11
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status[8:0] != 9'd0));
endmodule

bind uart_fifo_status ufs_checker u_ufs_checker (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_pop(rx_pop),
    .rx_full(rx_full), .rx_flush(rx_flush), .tx_flush(tx_flush),
    .tx_push(tx_push), .tx_take(tx_take), .status(status), .irq(irq)
);

// File: tb/test_uart_fifo_status.sv
`timescale 1ns/1ps
module test_uart_fifo_status;
    localparam int D   = 8;
    localparam int CB  = 2;
    localparam int TPC = 16 * CB;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, rx_valid, rx_perr, rx_ferr, rx_pop, tx_push, tx_take, tx_busy;
    logic nack, tx_flush, rx_flush, tick16, ien_we;
    logic [7:0] rx_char, tx_char, tx_char_out, tmo_chars;
    logic [8:0] ien_wdata;
    logic [9:0] rx_word;
    logic [10:0] status;
    logic irq;

    uart_fifo_status #(.DEPTH(D), .CHAR_BITS(CB)) i_uart_fifo_status (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_char(rx_char),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_pop(rx_pop), .rx_word(rx_word),
        .tx_push(tx_push), .tx_char(tx_char), .tx_take(tx_take),
        .tx_char_out(tx_char_out), .tx_busy(tx_busy), .nack(nack),
        .tx_flush(tx_flush), .rx_flush(rx_flush), .tmo_chars(tmo_chars),
        .tick16(tick16), .ien_we(ien_we), .ien_wdata(ien_wdata),
        .status(status), .irq(irq)
    );

    int vectors = 0, miscompares = 0;
    bit done = 0;
    logic [9:0] rxq[$];
    logic [7:0] txq[$];
    bit ovr_m, tmo_m;
    logic [8:0] ien_m;

    function automatic logic [10:0] model_status();
        logic [10:0] s = '0;
        s[0]  = rxq.size() != 0;
        s[1]  = (txq.size() == 0) && !tx_busy;
        s[2]  = txq.size() <= D / 2;
        s[3]  = (rxq.size() != 0) && rxq[0][8];
        s[4]  = (rxq.size() != 0) && rxq[0][9];
        s[5]  = ovr_m;
        s[6]  = txq.size() != 0;
        s[7]  = tmo_m;
        s[8]  = rxq.size() >= D / 2;
        s[9]  = txq.size() == D;
        s[10] = nack;
        return s;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_status(input string tag);
        logic [10:0] e = model_status();
        check(status == e, tag, 32'(status), 32'(e));
        check(irq == |(e[8:0] & ien_m), {tag, " irq"}, 32'(irq), 32'(|(e[8:0] & ien_m)));
    endtask

    task automatic rx_send(input logic [7:0] d, input bit pe, input bit fe);
        @(negedge clk);
        rx_valid = 1; rx_char = d; rx_perr = pe; rx_ferr = fe;
        @(negedge clk);
        rx_valid = 0;
        if (rxq.size() < D) rxq.push_back({fe, pe, d});
        else ovr_m = 1;
        tmo_m = 0;
    endtask

    // monitor side: compares the head entry, then removes it
    task automatic rx_read(input string tag);
        @(negedge clk);
        if (rxq.size() != 0) check(rx_word == rxq[0], tag, 32'(rx_word), 32'(rxq[0]));
        rx_pop = 1;
        @(negedge clk);
        rx_pop = 0;
        if (rxq.size() != 0) begin
            void'(rxq.pop_front());
            ovr_m = 0;
        end
        tmo_m = 0;
    endtask

    task automatic tx_put(input logic [7:0] c);
        @(negedge clk);
        tx_push = 1; tx_char = c;
        @(negedge clk);
        tx_push = 0;
        if (txq.size() < D) txq.push_back(c);
    endtask

    task automatic tx_get(input string tag);
        @(negedge clk);
        if (txq.size() != 0) check(tx_char_out == txq[0], tag, 32'(tx_char_out), 32'(txq[0]));
        tx_take = 1;
        @(negedge clk);
        tx_take = 0;
        if (txq.size() != 0) void'(txq.pop_front());
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick16 = 1;
        repeat (n) @(negedge clk);
        tick16 = 0;
    endtask

    task automatic set_ien(input logic [8:0] v);
        @(negedge clk);
        ien_we = 1; ien_wdata = v;
        @(negedge clk);
        ien_we = 0;
        ien_m = v;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1; rx_valid = 0; rx_char = 0; rx_perr = 0; rx_ferr = 0; rx_pop = 0;
        tx_push = 0; tx_char = 0; tx_take = 0; tx_busy = 0; nack = 0;
        tx_flush = 0; rx_flush = 0; tmo_chars = 0; tick16 = 0; ien_we = 0; ien_wdata = 0;
        ovr_m = 0; tmo_m = 0; ien_m = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(status == 11'h006, "R1 reset status", 32'(status), 32'h006);
        check(irq == 1'b0, "R1 reset irq", 32'(irq), 0);

        nack = 1; @(negedge clk);
        check_status("R12 nack high");
        nack = 0; @(negedge clk);
        check_status("R12 nack low");

        // R2 ordering
        rx_send(8'h11, 0, 0); rx_send(8'h22, 0, 0); rx_send(8'h33, 0, 0);
        check_status("R2 three stored");
        for (int i = 0; i < 3; i++) rx_read("R2 rx order");
        check_status("R2 drained");

        // R7 head error marks
        rx_send(8'h55, 1, 0); rx_send(8'hAA, 0, 1);
        check_status("R7 parity at head");
        rx_read("R7 rx word parity");
        check_status("R7 framing at head");
        rx_read("R7 rx word framing");
        check_status("R7 empty");

        // R3 / R5 / R6 receive levels and overrun
        for (int i = 0; i < D; i++) begin
            rx_send(8'h40 + 8'(i), 0, 0);
            if (i == D / 2 - 2 || i == D / 2 - 1 || i == D - 1) check_status("R3 rx level");
        end
        rx_send(8'hEE, 1, 1);
        check_status("R5 overrun raised");
        rx_read("R5 contents kept");
        check_status("R6 overrun cleared by pop");
        while (rxq.size() != 0) rx_read("R5 rx order after overrun");
        check_status("R5 drained");

        // R3 / R4 / R8 transmit side
        tx_busy = 1;
        for (int i = 0; i < D + 2; i++) begin
            tx_put(8'h80 + 8'(i));
            if (i == D / 2 - 1 || i == D / 2 || i >= D - 1) check_status("R3 R4 tx level");
        end
        for (int i = 0; i < D; i++) tx_get("R4 tx order");
        check_status("R8 busy blocks idle");
        tx_busy = 0; @(negedge clk);
        check_status("R8 idle");

        // R6 / R9 flush
        for (int i = 0; i < D + 1; i++) rx_send(8'h60 + 8'(i), 0, 0);
        tx_put(8'h01); tx_put(8'h02);
        check_status("R9 before flush");
        @(negedge clk);
        rx_flush = 1; tx_flush = 1; rx_valid = 1; tx_push = 1; rx_char = 8'h77; tx_char = 8'h78;
        @(negedge clk);
        rx_flush = 0; tx_flush = 0; rx_valid = 0; tx_push = 0;
        rxq.delete(); txq.delete(); ovr_m = 0; tmo_m = 0;
        check_status("R9 R6 after flush");

        // R10 / R11 timeout and interrupt
        set_ien(9'h080);
        tmo_chars = 2;
        rx_send(8'h5A, 0, 0);
        ticks(2 * TPC - 1);
        check_status("R10 one tick short");
        ticks(1);
        tmo_m = 1;
        check_status("R10 R11 timeout fires");
        rx_read("R10 read clears");
        check_status("R10 cleared by read");

        rx_send(8'h5B, 0, 0);
        ticks(40);
        rx_send(8'h5C, 0, 0);
        ticks(40);
        check_status("R10 restarted by arrival");
        ticks(2 * TPC - 40);
        tmo_m = 1;
        check_status("R10 fires after restart");

        set_ien(9'h001);
        check_status("R11 rx-not-empty enable");
        set_ien(9'h000);
        check_status("R11 all masked");
        rx_read("R10 drain a");
        rx_read("R10 drain b");

        tmo_chars = 0;
        rx_send(8'h5D, 0, 0);
        ticks(6 * TPC);
        check_status("R10 zero limit never fires");
        rx_read("R10 drain c");
        check_status("R1 final idle");

        finish_run();
    end
endmodule